// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status Flags

This block turns an asynchronous serial line into parallel words. A baud generator outside the block supplies a clock enable at sixteen times the bit rate. The receiver runs on that enable, qualifies a falling edge as a start bit, and samples each data bit, least significant first, near the centre of its bit period. It then samples an optional parity bit and a single stop bit.

Each completed word goes into a receive buffer register. Five sticky flags describe the receive path: data ready, overrun, parity error, framing error and break. The host clears data ready with a buffer read strobe and clears the four error flags with a status read strobe. Two interrupt request outputs follow the flags. One means a word is waiting. The other means an error flag is set.

Top module: `uart_rx_core`

## Requirements
- R1: `word_len_i` sets the data width to 5 + `word_len_i` bits (0 gives 5 bits, 3 gives 8 bits). The first data bit after the start bit lands in `rx_data_o[0]`, and buffer bits above the selected width read 0.
- R2: With `parity_en_i` high, one parity bit follows the data. For even parity (`parity_even_i` high) the count of ones over data and parity must be even; for odd parity it must be odd. A mismatch sets `parity_err_o`. With `parity_en_i` low no parity bit is expected and `parity_err_o` is not set.
- R3: A low level sampled at the centre of the stop bit sets `frame_err_o`. Only one stop bit is checked.
- R4: If every sampled bit of a frame is low, including parity and stop, the block sets `break_o` and `frame_err_o` and loads 0 into the buffer. No new start bit is accepted until the line has returned high.
- R5: `data_ready_o` rises in the cycle after the stop-bit sample, when the word is loaded. A one-cycle `rd_buf_i` pulse clears it by the next cycle. `rx_data_o` changes only when a new word is loaded.
- R6: A word that arrives while `data_ready_o` is still set, with no `rd_buf_i` in the same cycle, sets `overrun_o` and replaces the buffer contents. A buffer read does not clear `overrun_o`.
- R7: A one-cycle `rd_status_i` pulse clears overrun, parity, framing and break flags by the next cycle. It leaves `data_ready_o` unchanged. A flag set in the same cycle as the read stays set.
- R8: `irq_rda_o` is high exactly while `data_ready_o` is high. `irq_rls_o` is high exactly while any of the four error flags is high.
- R9: A low pulse on `rx_i` that returns high before the start-bit midpoint (8 oversample enables) produces no word. The receiver is ready for the next frame.
- R10: Timing advances only on `os_tick_i`. Bit periods are 16 enables long, whatever the ratio of clock to enable.
- R11: After reset every flag, both interrupt requests and `rx_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample enable, 16 per bit |
| rx_i | input | 1 | Serial input, idle high |
| word_len_i | input | 2 | Data width select, 5 + value bits |
| parity_en_i | input | 1 | Parity bit present |
| parity_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| rd_buf_i | input | 1 | Host read strobe of the receive buffer |
| rd_status_i | input | 1 | Host read strobe of the status flags |
| rx_data_o | output | 8 | Receive buffer |
| data_ready_o | output | 1 | Word waiting in buffer |
| overrun_o | output | 1 | Unread word was overwritten |
| parity_err_o | output | 1 | Parity mismatch seen |
| frame_err_o | output | 1 | Stop bit sampled low |
| break_o | output | 1 | All-low frame seen |
| irq_rda_o | output | 1 | Received-data-available request |
| irq_rls_o | output | 1 | Receiver-line-status request |

## Verification
A wrong bit counter or sample phase shows up in the first frame of the affected width. Either the buffer holds shifted or truncated bits, or the parity and framing flags fire on clean traffic. Both are visible about half a bit period after the stop bit starts. A stuck or wrongly cleared flag shows at the flag and interrupt ports in the cycle right after the load or the read strobe. A receiver that fails to leave its break or glitch handling never raises `data_ready_o` for the next clean frame, so the next frame exposes it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int WL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= 1'b1;
        else         sync_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [WL_W-1:0]   word_len_i,
  input  logic              parity_en_i,
  input  logic              parity_even_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OS_RATE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shf_q;
  logic              par_q, seen_q, perr_q;
  logic [IDX_W-1:0]  last_idx;
  logic              bit_end;

  assign last_idx = IDX_W'(DATA_W - 4) + IDX_W'(word_len_i);
  assign bit_end  = tick_i && (cnt_q == END_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
      seen_q  <= 1'b0;
      perr_q  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && state_q != ST_IDLE && state_q != ST_HOLD)
        cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (tick_i && !rx_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
        end
        ST_START: if (tick_i) begin
          if (rx_i) state_q <= ST_IDLE;  // glitch
          else if (cnt_q == MID_CNT) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
            shf_q   <= '0;
            par_q   <= 1'b0;
            seen_q  <= 1'b0;
            perr_q  <= 1'b0;
          end
        end
        ST_DATA: if (bit_end) begin
          shf_q[idx_q] <= rx_i;
          par_q        <= par_q ^ rx_i;
          seen_q       <= seen_q | rx_i;
          if (idx_q == last_idx) state_q <= parity_en_i ? ST_PAR : ST_STOP;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_PAR: if (bit_end) begin
          perr_q  <= rx_i ^ par_q ^ ~parity_even_i;
          seen_q  <= seen_q | rx_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (bit_end) begin
          done_o  <= 1'b1;
          data_o  <= shf_q;
          perr_o  <= perr_q;
          ferr_o  <= !rx_i;
          brk_o   <= !rx_i && !seen_q;
          state_q <= rx_i ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              brk_i,
  input  logic              rd_buf_i,
  input  logic              rd_status_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              dr_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              bi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o <= '0;
      dr_o  <= 1'b0;
      oe_o  <= 1'b0;
      pe_o  <= 1'b0;
      fe_o  <= 1'b0;
      bi_o  <= 1'b0;
    end else begin
      if (done_i) buf_o <= data_i;
      dr_o <= done_i | (dr_o & ~rd_buf_i);
      // set wins over a coincident status read
      oe_o <= (done_i & dr_o & ~rd_buf_i) | (oe_o & ~rd_status_i);
      pe_o <= (done_i & perr_i)           | (pe_o & ~rd_status_i);
      fe_o <= (done_i & ferr_i)           | (fe_o & ~rd_status_i);
      bi_o <= (done_i & brk_i)            | (bi_o & ~rd_status_i);
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_i,
  input  logic [1:0]        word_len_i,
  input  logic              parity_en_i,
  input  logic              parity_even_i,
  input  logic              rd_buf_i,
  input  logic              rd_status_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              data_ready_o,
  output logic              overrun_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              break_o,
  output logic              irq_rda_o,
  output logic              irq_rls_o
);
  logic              rx_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_perr, frame_ferr, frame_brk;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_deser #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_deser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (os_tick_i),
    .rx_i         (rx_s),
    .word_len_i   (word_len_i),
    .parity_en_i  (parity_en_i),
    .parity_even_i(parity_even_i),
    .done_o       (frame_done),
    .data_o       (frame_data),
    .perr_o       (frame_perr),
    .ferr_o       (frame_ferr),
    .brk_o        (frame_brk)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (frame_done),
    .data_i     (frame_data),
    .perr_i     (frame_perr),
    .ferr_i     (frame_ferr),
    .brk_i      (frame_brk),
    .rd_buf_i   (rd_buf_i),
    .rd_status_i(rd_status_i),
    .buf_o      (rx_data_o),
    .dr_o       (data_ready_o),
    .oe_o       (overrun_o),
    .pe_o       (parity_err_o),
    .fe_o       (frame_err_o),
    .bi_o       (break_o)
  );

  assign irq_rda_o = data_ready_o;
  assign irq_rls_o = overrun_o | parity_err_o | frame_err_o | break_o;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_buf_i,
  input logic              rd_status_i,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              data_ready_o,
  input logic              overrun_o,
  input logic              parity_err_o,
  input logic              frame_err_o,
  input logic              break_o,
  input logic              irq_rls_o
);
  assert_buf_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_buf_i && !frame_done |=> !data_ready_o);

  assert_buf_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done |=> $stable(rx_data_o));

  assert_overrun_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && data_ready_o && !rd_buf_i |=> overrun_o);

  assert_err_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_i && !frame_done |=> !(overrun_o | parity_err_o | frame_err_o | break_o));

  assert_break_fe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> frame_err_o);

  assert_rls_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_rls_o) |-> $past(frame_done));
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rx = 1'b1;
  logic [1:0] wl = 2'd3;
  logic       pen = 1'b0, peven = 1'b0;
  logic       rd_buf = 1'b0, rd_st = 1'b0;
  logic [7:0] dout;
  logic       dr, oe, pe, fe, bi, irq_rda, irq_rls;

  int checks = 0, errors = 0, cyc = 0, tdiv = 1, tcnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  uart_rx_core uut (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx),
    .word_len_i(wl), .parity_en_i(pen), .parity_even_i(peven),
    .rd_buf_i(rd_buf), .rd_status_i(rd_st),
    .rx_data_o(dout), .data_ready_o(dr), .overrun_o(oe), .parity_err_o(pe),
    .frame_err_o(fe), .break_o(bi), .irq_rda_o(irq_rda), .irq_rls_o(irq_rls)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int periods);
    rx = v;
    repeat (periods * 16 * tdiv) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input int w, input int pm);
    wl = 2'(w);
    pen = (pm != 0);
    peven = (pm == 2);
  endtask

  // pm: 0 none, 1 odd, 2 even
  task automatic send(input logic [7:0] d, input int w, input int pm,
                      input bit bad_par, input logic stop_v);
    int nb;
    logic p;
    nb = 5 + w;
    drive(1'b0, 1);
    for (int i = 0; i < nb; i++) drive(d[i], 1);
    if (pm != 0) begin
      p = (^(d & 8'((1 << nb) - 1))) ^ (pm == 1);
      if (bad_par) p = ~p;
      drive(p, 1);
    end
    drive(stop_v, 1);
    drive(1'b1, 2);
  endtask

  task automatic pulse_buf();
    rd_buf = 1'b1; @(posedge clk); #1; rd_buf = 1'b0;
  endtask

  task automatic pulse_st();
    rd_st = 1'b1; @(posedge clk); #1; rd_st = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d, m;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 data", dout, 0);
    chk("R11 flags", {dr, oe, pe, fe, bi, irq_rda, irq_rls}, 0);
    rst_n = 1'b1;
    drive(1'b1, 2);

    // R1 R2 sweep: all widths and parity modes, clean frames
    for (int w = 0; w < 4; w++)
      for (int pm = 0; pm < 3; pm++) begin
        set_mode(w, pm);
        for (int k = 0; k < 6; k++) begin
          d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 73 + 11);
          m = 8'((1 << (5 + w)) - 1);
          send(d, w, pm, 1'b0, 1'b1);
          chk("R1 data", dout, d & m);
          chk("R5 ready", dr, 1);
          chk("R8 rda", irq_rda, 1);
          chk("R2 no perr", {pe, fe, oe, bi, irq_rls}, 0);
          pulse_buf();
          chk("R5 cleared", {dr, irq_rda}, 0);
          chk("R5 buf held", dout, d & m);
        end
        if (pm != 0) begin
          send(8'h35, w, pm, 1'b1, 1'b1);
          chk("R2 perr", pe, 1);
          chk("R8 rls", irq_rls, 1);
          pulse_st();
          chk("R7 cleared", {pe, irq_rls}, 0);
          chk("R7 dr kept", dr, 1);
          pulse_buf();
        end
      end

    // R3 bad stop bit
    set_mode(3, 0);
    send(8'h5A, 3, 0, 1'b0, 1'b0);
    chk("R3 fe", {fe, bi, irq_rls}, 3'b101);
    chk("R3 data", dout, 8'h5A);
    pulse_st(); pulse_buf();
    chk("R7 fe clear", {fe, dr}, 0);

    // R4 break
    drive(1'b0, 12);
    drive(1'b1, 2);
    chk("R4 break", {bi, fe, dr, pe}, 4'b1110);
    chk("R4 data", dout, 0);
    pulse_st(); pulse_buf();
    chk("R4 cleared", {bi, fe, dr}, 0);
    send(8'hA5, 3, 0, 1'b0, 1'b1);
    chk("R4 recover", dout, 8'hA5);
    chk("R4 no bi", bi, 0);
    pulse_buf();

    // R6 overrun
    send(8'h11, 3, 0, 1'b0, 1'b1);
    send(8'h22, 3, 0, 1'b0, 1'b1);
    chk("R6 oe", {oe, dr, irq_rls}, 3'b111);
    chk("R6 data", dout, 8'h22);
    pulse_buf();
    chk("R6 oe kept", {oe, dr}, 2'b10);
    pulse_st();
    chk("R6 oe clear", oe, 0);

    // R9 glitch shorter than half a bit
    rx = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    drive(1'b1, 3);
    chk("R9 glitch", dr, 0);
    send(8'h3C, 3, 0, 1'b0, 1'b1);
    chk("R9 after glitch", dout, 8'h3C);
    pulse_buf();

    // R10 slower enable
    tdiv = 3;
    drive(1'b1, 1);
    set_mode(2, 2);
    send(8'h6B, 2, 2, 1'b0, 1'b1);
    chk("R10 data", dout, 8'h6B & 8'h7F);
    chk("R10 flags", {dr, pe, fe}, 3'b100);
    pulse_buf();

    finish_run();
  end
endmodule